// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Writes

This block is a memory-mapped general-purpose I/O controller for 118 pins split into four banks of unequal width: bank 0 holds pins 0 to 31, bank 1 holds pins 32 to 53 (22 pins), bank 2 holds pins 54 to 85 and bank 3 holds pins 86 to 117. Each bank keeps an output value word, a direction word, an output-enable word and an interrupt mask word. Pin inputs pass through a two-stage synchronizer and are read back through a separate read-only pin-state register.

Software can overwrite a whole bank's outputs in one write. It can also change any subset of sixteen outputs atomically through one of two half-word masked-write registers, which needs no read-modify-write. A pin drives only when its direction bit and its output-enable bit are both set. Reads are combinational on the address, so the read word is valid in the same cycle as the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, all output values, direction, output-enable and interrupt mask words are 0, and every `pin_oe` and `pin_out` bit is 0.
- R2: A write to register 0 of a bank (address = bank*8 + 0) replaces every output bit of that bank with the write data. The new value appears on `pin_out` after the next clock edge and reads back from register 0.
- R3: A write to register 2 of a bank (masked low) updates output bit i (0..15) to `wdata[i]` only where `wdata[16+i]` is 0. Output bits with a mask bit of 1, and bits 31:16, keep their value.
- R4: A write to register 3 of a bank (masked high) updates output bit 16+i to `wdata[i]` only where `wdata[16+i]` is 0. Output bits with a mask bit of 1, and bits 15:0, keep their value.
- R5: `pin_oe` of a pin is 1 exactly when both its direction bit and its output-enable bit are 1. `pin_out` always shows the stored output value. With no write in a cycle, `pin_out` and `pin_oe` hold.
- R6: The direction word (register 4) and the output-enable word (register 5) are written whole and read back as written.
- R7: Register 1 (pin state, read-only) returns `pin_in` of the bank as sampled two clock edges earlier. Register 0 returns the stored output value, never the pins.
- R8: Writing register 6 (interrupt disable) ORs the written 1 bits into the bank's interrupt mask; 0 bits have no effect. Register 7 reads the mask word, and register 6 reads 0.
- R9: Bank 1 stores only 22 bits. Register bits 31:22 of bank 1 read 0 and ignore writes, and bank 2's bit 0 is pin 54.
- R10: Addresses with any bit above bit 4 set read 0 and their writes change nothing. Registers 2 and 3 read 0. Writes to registers 1 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Word address: bits 4:3 bank, bits 2:0 register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 118 | Pin input levels |
| pin_out | output | 118 | Pin output values |
| pin_oe | output | 118 | Pin driver enables |

## Verification
The bench aims at masked writes with mixed mask patterns on top of non-zero prior outputs. A design that inverted the mask sense or used the wrong half would corrupt bits that should hold. It checks that bank 1's narrow width keeps bits 31:22 at zero and that bank 2 starts at pin 54; an off-by-one in the bank offsets would show up on the wrong `pin_out` bits. It probes the pin-state read one and two edges after an input change, so a missing or extra synchronizer stage shows up. It also confirms that interrupt-disable writes only ever set mask bits, and that unmapped and read-only addresses swallow writes without side effects.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NUM_BANKS  = 4;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = DATA_W / 2;
    localparam int REG_SEL_W  = 3;
    localparam int BANK_SEL_W = $clog2(NUM_BANKS);
    localparam int MAP_W      = REG_SEL_W + BANK_SEL_W;

    // register index inside a bank; the software map depends on these codes
    typedef enum logic [REG_SEL_W-1:0] {
        REG_DATA  = 3'd0,
        REG_PINS  = 3'd1,
        REG_MLO   = 3'd2,
        REG_MHI   = 3'd3,
        REG_DIR   = 3'd4,
        REG_OEN   = 3'd5,
        REG_IDIS  = 3'd6,
        REG_IMSK  = 3'd7
    } reg_sel_e;

    function automatic int bank_width(input int b);
        case (b)
            1:       return 22;
            default: return DATA_W;
        endcase
    endfunction

    function automatic int bank_offset(input int b);
        int acc;
        acc = 0;
        for (int k = 0; k < b; k++) acc += bank_width(k);
        return acc;
    endfunction

    function automatic int total_pins();
        return bank_offset(NUM_BANKS);
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    output logic                  hit,
    output reg_sel_e              sel,
    output logic [BANK_SEL_W-1:0] bank,
    output logic [NUM_BANKS-1:0]  bank_wr
);

    always_comb begin
        sel     = reg_sel_e'(addr[REG_SEL_W-1:0]);
        bank    = addr[MAP_W-1:REG_SEL_W];
        hit     = (addr[ADDR_W-1:MAP_W] == '0);
        bank_wr = '0;
        if (wr && hit) bank_wr[bank] = 1'b1;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [WIDTH-1:0]  dout_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  oen_q,
    output logic [WIDTH-1:0]  imask_q
);

    typedef struct packed {
        logic [WIDTH-1:0] dout;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] oen;
        logic [WIDTH-1:0] imask;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                REG_DATA: st_d.dout = wdata[WIDTH-1:0];
                REG_MLO: begin
                    // mask for bit i sits HALF_W above it; 0 lets the bit change
                    for (int i = 0; i < WIDTH; i++) begin
                        if (i < HALF_W && !wdata[(i + HALF_W) % DATA_W])
                            st_d.dout[i] = wdata[i];
                    end
                end
                REG_MHI: begin
                    for (int i = 0; i < WIDTH; i++) begin
                        if (i >= HALF_W && !wdata[i])
                            st_d.dout[i] = wdata[(i + HALF_W) % DATA_W];
                    end
                end
                REG_DIR:  st_d.dir   = wdata[WIDTH-1:0];
                REG_OEN:  st_d.oen   = wdata[WIDTH-1:0];
                REG_IDIS: st_d.imask = st_q.imask | wdata[WIDTH-1:0];
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_q  = st_q.dout;
    assign dir_q   = st_q.dir;
    assign oen_q   = st_q.oen;
    assign imask_q = st_q.imask;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter  int ADDR_W = 8,
    localparam int NPINS  = total_pins()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);

    logic                  hit;
    reg_sel_e              sel;
    logic [BANK_SEL_W-1:0] bank;
    logic [NUM_BANKS-1:0]  bank_wr;
    logic [NPINS-1:0]      pins_sync;
    logic [DATA_W-1:0]     rd_bank [NUM_BANKS];

    gpio_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .hit     (hit),
        .sel     (sel),
        .bank    (bank),
        .bank_wr (bank_wr)
    );

    gpio_in_sync #(.WIDTH(NPINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int W   = bank_width(b);
        localparam int OFF = bank_offset(b);

        logic [W-1:0]      dout, dir, oen, imask;
        logic [DATA_W-1:0] rd_word;

        gpio_bank_regs #(.WIDTH(W)) regs_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr[b]),
            .sel     (sel),
            .wdata   (bus_wdata),
            .dout_q  (dout),
            .dir_q   (dir),
            .oen_q   (oen),
            .imask_q (imask)
        );

        assign pin_out[OFF +: W] = dout;
        assign pin_oe[OFF +: W]  = dir & oen;

        always_comb begin
            case (sel)
                REG_DATA: rd_word = DATA_W'(dout);
                REG_PINS: rd_word = DATA_W'(pins_sync[OFF +: W]);
                REG_DIR:  rd_word = DATA_W'(dir);
                REG_OEN:  rd_word = DATA_W'(oen);
                REG_IMSK: rd_word = DATA_W'(imask);
                default:  rd_word = '0;
            endcase
        end

        assign rd_bank[b] = rd_word;
    end

    always_comb begin
        bus_rdata = hit ? rd_bank[bank] : '0;
    end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int NPINS  = 118
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_wr,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0));

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(16)) |=> pin_out[54 +: 32] == $past(bus_wdata));

    // R3
    mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(2)) |=>
        pin_out[15:0] == (($past(pin_out[15:0]) & $past(bus_wdata[31:16]))
                        | ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16]))));

    // R4
    mask_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(27)) |=>
        pin_out[102 +: 16] == (($past(pin_out[102 +: 16]) & $past(bus_wdata[31:16]))
                             | ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16]))));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

    // R7
    pin_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && bus_addr == ADDR_W'(1)) |-> bus_rdata == $past(pin_in[31:0], 2));

    // R8
    idis_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[2:0] == 3'd6) |-> bus_rdata == '0);

    // R9
    narrow_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(1)) |-> bus_rdata[31:22] == '0);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:5] != '0) |-> bus_rdata == '0);

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.ADDR_W(ADDR_W), .NPINS(NPINS)) chk_i (.*);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;

    localparam int AW = 8;
    localparam int NP = 118;
    localparam int OFFS [4] = '{0, 32, 54, 86};
    localparam int WIDS [4] = '{32, 22, 32, 32};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_out [4];
    logic [31:0] m_dir [4];
    logic [31:0] m_oen [4];
    logic [31:0] m_imk [4];

    always #5 clk = ~clk;

    gpio_bank_ctrl #(.ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    function automatic logic [31:0] width_mask(input int b);
        return (b == 1) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] masked(input logic [31:0] old, input logic [31:0] w, input bit hi);
        logic [31:0] r;
        r = old;
        for (int i = 0; i < 16; i++)
            if (!w[16 + i]) r[(hi ? 16 : 0) + i] = w[i];
        return r;
    endfunction

    function automatic logic [31:0] pin_slice(input logic [NP-1:0] v, input int b);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < WIDS[b]; i++) r[i] = v[OFFS[b] + i];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input int b, input int r);
        case (r)
            0:       return m_out[b];
            1:       return pin_slice(pin_in, b);
            4:       return m_dir[b];
            5:       return m_oen[b];
            7:       return m_imk[b];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(input int b, input int r, input logic [31:0] d);
        case (r)
            0: m_out[b] = d & width_mask(b);
            2: m_out[b] = masked(m_out[b], d, 1'b0) & width_mask(b);
            3: m_out[b] = masked(m_out[b], d, 1'b1) & width_mask(b);
            4: m_dir[b] = d & width_mask(b);
            5: m_oen[b] = d & width_mask(b);
            6: m_imk[b] = m_imk[b] | (d & width_mask(b));
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic reg_write(input int b, input int r, input logic [31:0] d);
        bus_write(AW'(b * 8 + r), d);
        model_write(b, r, d);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic read_check(input int b, input int r, input string tag);
        logic [31:0] v;
        bus_read(AW'(b * 8 + r), v);
        check(tag, 128'(v), 128'(exp_read(b, r)));
    endtask

    task automatic pins_check(input string tag);
        logic [NP-1:0] eo, ee;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < WIDS[b]; i++) begin
                eo[OFFS[b] + i] = m_out[b][i];
                ee[OFFS[b] + i] = m_dir[b][i] & m_oen[b][i];
            end
        check({tag, " pin_out"}, 128'(pin_out), 128'(eo));
        check({tag, " pin_oe"}, 128'(pin_oe), 128'(ee));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0]   v;
        logic [NP-1:0] old_pins;
        for (int b = 0; b < 4; b++) begin
            m_out[b] = '0; m_dir[b] = '0; m_oen[b] = '0; m_imk[b] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on pins and in every register
        pins_check("R1 reset");
        for (int b = 0; b < 4; b++) begin
            read_check(b, 0, "R1 data reset");
            read_check(b, 4, "R1 dir reset");
            read_check(b, 5, "R1 oen reset");
            read_check(b, 7, "R1 imask reset");
        end

        // R2: full-word replace
        reg_write(0, 0, 32'hA5A5_5A5A);
        pins_check("R2 full write");
        read_check(0, 0, "R2 readback");
        reg_write(2, 0, 32'h1234_5678);
        pins_check("R2 bank2 write");

        // R3: masked low half on non-zero prior value
        reg_write(0, 2, 32'h00FF_1234);
        pins_check("R3 mask low");
        read_check(0, 0, "R3 readback");
        reg_write(0, 2, 32'hFFFF_0000);
        pins_check("R3 all masked");

        // R4: masked high half
        reg_write(2, 3, 32'h0F0F_BEEF);
        pins_check("R4 mask high");
        reg_write(3, 3, 32'h0000_C3C3);
        pins_check("R4 bank3 high");
        read_check(3, 0, "R4 readback");

        // R9: narrow bank and bank 2 start pin
        reg_write(1, 0, 32'hFFFF_FFFF);
        pins_check("R9 bank1 ones");
        read_check(1, 0, "R9 bank1 width");
        check("R9 pin54 untouched", 128'(pin_out[54]), 128'(m_out[2][0]));
        reg_write(1, 3, 32'h0000_FFFF);
        read_check(1, 0, "R9 bank1 high half");

        // R5/R6: drive enable needs both words
        reg_write(0, 4, 32'hFF00_FF00);
        reg_write(0, 5, 32'hF0F0_F0F0);
        pins_check("R5 oe and");
        read_check(0, 4, "R6 dir readback");
        read_check(0, 5, "R6 oen readback");

        // R7: two-edge synchronizer latency, data reg ignores pins
        old_pins = pin_in;
        @(negedge clk);
        pin_in   = {NP{1'b1}};
        bus_addr = AW'(1);
        @(negedge clk);
        #1;
        check("R7 one edge old", 128'(bus_rdata), 128'(pin_slice(old_pins, 0)));
        @(negedge clk);
        #1;
        check("R7 two edges new", 128'(bus_rdata), 128'(pin_slice(pin_in, 0)));
        read_check(1, 1, "R7 bank1 pins");
        read_check(0, 0, "R7 data not pins");

        // R8: interrupt disable only sets
        reg_write(0, 6, 32'h0000_00F0);
        reg_write(0, 6, 32'h0F00_0000);
        read_check(0, 7, "R8 mask accumulates");
        read_check(0, 6, "R8 idis reads zero");
        reg_write(1, 6, 32'hFFFF_FFFF);
        read_check(1, 7, "R8 bank1 mask width");

        // R10: unmapped and read-only addresses
        bus_write(AW'(8'h20), 32'hDEAD_BEEF);
        bus_read(AW'(8'h20), v);
        check("R10 unmapped read", 128'(v), 128'(0));
        bus_write(AW'(8'hE0), 32'hFFFF_0000);
        bus_write(AW'(1), 32'h0);
        bus_write(AW'(7), 32'h0);
        pins_check("R10 no side effect");
        read_check(0, 7, "R10 imask unchanged");
        read_check(0, 2, "R10 mask low reads zero");
        read_check(2, 3, "R10 mask high reads zero");

        // random mix over all banks and registers
        for (int k = 0; k < 400; k++) begin
            int b, r;
            logic [31:0] d;
            b = int'($urandom % 4);
            r = int'($urandom % 8);
            d = $urandom;
            if (k % 20 == 0) begin
                @(negedge clk);
                pin_in = {$urandom, $urandom, $urandom, $urandom};
                @(negedge clk);
                @(negedge clk);
                read_check(b, 1, "R7 random pins");
            end
            if ($urandom % 10 == 0) begin
                bus_write(AW'({3'($urandom % 7 + 1), 5'($urandom)}), d);
                pins_check("R10 random unmapped");
            end else begin
                reg_write(b, r, d);
                pins_check((r == 2) ? "R3 random" : (r == 3) ? "R4 random" : "R2 R5 random");
                read_check(b, (r == 0 || r == 2 || r == 3) ? 0 : (r == 6 ? 7 : r),
                           "R6 R8 R9 random readback");
            end
        end

        finish_run();
    end

endmodule